// File: doc/BRIEF.md
# Calendar Shadow Register Read Path

This block sits between a calendar counter clocked by the real-time clock and a bus read port clocked by the bus clock. Every two real-time clock cycles it snapshots the live sub-second, time and date values and carries them into three shadow registers in the bus domain. Each completed transfer raises a sticky "synchronized" flag. Software may clear this flag and then wait for it to return before it reads again.

A read of the sub-second or time shadow freezes all three shadows. They stay frozen until the date shadow is read, so one time-and-date triple read over three bus accesses is always coherent. While the shadows are frozen, any copy that falls due is skipped. A bypass input routes reads directly from the live counters, and reads made in bypass never freeze the shadows.

The bus clock must never be slower than the real-time clock. Coherent values without re-reading assume a bus clock at least seven times faster.

Top module: `cal_shadow_path`

## Requirements
- R1: After reset all three shadows read zero, the synchronized flag is 0 and the shadows are not frozen.
- R2: While not frozen, the shadows take a fresh snapshot of the live values once every two real-time clock cycles. Within six real-time clock cycles of a change, every shadow read returns the new live value.
- R3: The synchronized flag is set when a copy into the shadows completes.
- R4: A one-cycle pulse on `flag_clr` clears the synchronized flag from the next bus clock edge. The flag stays clear until the next completed copy. If a copy lands in the same cycle as the clear, the set wins.
- R5: A non-bypass read with `rd_sel` 0 (sub-second) or 1 (time) freezes all three shadows from the next bus clock edge.
- R6: A non-bypass read with `rd_sel` 2 (date) returns the frozen date and releases the freeze. Copying and flag setting then resume at the next copy point.
- R7: A date read while the shadows are not frozen does not freeze them.
- R8: With `bypass` high, reads return the live values directly, and no read freezes the shadows.
- R9: `rd_sel` encoding: 0 selects sub-second, 1 selects time, 2 selects date and 3 returns zero. Values are zero-extended into `rd_data`.
- R10: A copy that falls due while the shadows are frozen is skipped and does not set the synchronized flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rtc_clk | input | 1 | Real-time clock |
| bus_clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| live_subsec | input | SS_W (16) | Live sub-second count, RTC domain |
| live_time | input | TM_W (24) | Live time of day, RTC domain |
| live_date | input | DT_W (24) | Live date, RTC domain |
| bypass | input | 1 | 1 = read live values, no freeze |
| rd_en | input | 1 | Read strobe, one bus cycle per access |
| rd_sel | input | 2 | Register select (see R9) |
| flag_clr | input | 1 | Pulse to clear the synchronized flag |
| rd_data | output | DATA_W (24) | Combinational read data |
| sync_flag | output | 1 | Sticky synchronized flag |

## Verification
A copy is due at most two real-time clock cycles after the live values change. It then passes through three synchronizer and edge flops and one shadow flop in the bus domain, so the bench allows six real-time cycles before it compares any shadow or the flag. Freeze and flag-clear effects are due at the bus edge after the strobe, and the bench samples them one bus cycle later, away from the edge. Read data is combinational and is sampled during the strobe cycle. Live values change only on real-time falling edges, so each snapshot is clean.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;
    typedef enum logic [1:0] {
        SEL_SUBSEC = 2'd0,
        SEL_TIME   = 2'd1,
        SEL_DATE   = 2'd2,
        SEL_NONE   = 2'd3
    } cal_sel_e;
endpackage

// File: rtl/cal_copy_tick.sv
module cal_copy_tick #(
    parameter int SS_W = 16,
    parameter int TM_W = 24,
    parameter int DT_W = 24
) (
    input  logic            rtc_clk,
    input  logic            rst_n,
    input  logic [SS_W-1:0] live_subsec,
    input  logic [TM_W-1:0] live_time,
    input  logic [DT_W-1:0] live_date,
    output logic [SS_W-1:0] stage_subsec,
    output logic [TM_W-1:0] stage_time,
    output logic [DT_W-1:0] stage_date,
    output logic            copy_tgl
);
    typedef struct packed {
        logic            phase;
        logic            tgl;
        logic [SS_W-1:0] ss;
        logic [TM_W-1:0] tm;
        logic [DT_W-1:0] dt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        if (st_q.phase) begin
            st_d.tgl = ~st_q.tgl;
            st_d.ss  = live_subsec;
            st_d.tm  = live_time;
            st_d.dt  = live_date;
        end
    end

    always_ff @(posedge rtc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_subsec = st_q.ss;
    assign stage_time   = st_q.tm;
    assign stage_date   = st_q.dt;
    assign copy_tgl     = st_q.tgl;

    // R2: the toggle flips at most every second RTC cycle
    p_copy_every_two_r2: assert property (@(posedge rtc_clk) disable iff (!rst_n)
        (st_q.tgl != $past(st_q.tgl)) |=> (st_q.tgl == $past(st_q.tgl)));
endmodule

// File: rtl/cal_toggle_sync.sv
module cal_toggle_sync (
    input  logic bus_clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_st_t;

    sync_st_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = tgl_in;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign pulse = sy_q.s2 ^ sy_q.s3;

    // R2: one bus-domain pulse per copy, never two in a row
    p_single_pulse_r2: assert property (@(posedge bus_clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/cal_shadow_path.sv
module cal_shadow_path
    import cal_shadow_pkg::*;
#(
    parameter int SS_W = 16,
    parameter int TM_W = 24,
    parameter int DT_W = 24,
    localparam int W01    = (SS_W > TM_W) ? SS_W : TM_W,
    localparam int DATA_W = (W01 > DT_W) ? W01 : DT_W
) (
    input  logic              rtc_clk,
    input  logic              bus_clk,
    input  logic              rst_n,
    input  logic [SS_W-1:0]   live_subsec,
    input  logic [TM_W-1:0]   live_time,
    input  logic [DT_W-1:0]   live_date,
    input  logic              bypass,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sync_flag
);
    logic [SS_W-1:0] stage_ss;
    logic [TM_W-1:0] stage_tm;
    logic [DT_W-1:0] stage_dt;
    logic            copy_tgl;
    logic            copy_pulse;

    cal_copy_tick #(.SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W)) u_tick (
        .rtc_clk      (rtc_clk),
        .rst_n        (rst_n),
        .live_subsec  (live_subsec),
        .live_time    (live_time),
        .live_date    (live_date),
        .stage_subsec (stage_ss),
        .stage_time   (stage_tm),
        .stage_date   (stage_dt),
        .copy_tgl     (copy_tgl)
    );

    cal_toggle_sync u_sync (
        .bus_clk (bus_clk),
        .rst_n   (rst_n),
        .tgl_in  (copy_tgl),
        .pulse   (copy_pulse)
    );

    typedef struct packed {
        logic [SS_W-1:0] ss;
        logic [TM_W-1:0] tm;
        logic [DT_W-1:0] dt;
        logic            lock;
        logic            flag;
    } shd_st_t;

    shd_st_t sh_d, sh_q;
    logic    copy_en;
    logic    rd_freeze;
    logic    rd_release;
    cal_sel_e sel;

    assign sel        = cal_sel_e'(rd_sel);
    assign copy_en    = copy_pulse && !sh_q.lock;
    assign rd_freeze  = rd_en && !bypass && (sel == SEL_SUBSEC || sel == SEL_TIME);
    assign rd_release = rd_en && !bypass && (sel == SEL_DATE);

    always_comb begin
        sh_d = sh_q;
        if (copy_en) begin
            sh_d.ss = stage_ss;
            sh_d.tm = stage_tm;
            sh_d.dt = stage_dt;
        end
        if (rd_freeze)       sh_d.lock = 1'b1;
        else if (rd_release) sh_d.lock = 1'b0;
        if (copy_en)         sh_d.flag = 1'b1;
        else if (flag_clr)   sh_d.flag = 1'b0;
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    always_comb begin
        unique case (sel)
            SEL_SUBSEC: rd_data = bypass ? DATA_W'(live_subsec) : DATA_W'(sh_q.ss);
            SEL_TIME:   rd_data = bypass ? DATA_W'(live_time)   : DATA_W'(sh_q.tm);
            SEL_DATE:   rd_data = bypass ? DATA_W'(live_date)   : DATA_W'(sh_q.dt);
            default:    rd_data = '0;
        endcase
    end

    assign sync_flag = sh_q.flag;

    // R5 / R10: frozen shadows hold still
    p_frozen_stable_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
        sh_q.lock |=> $stable({sh_q.ss, sh_q.tm, sh_q.dt}));
    // R10: no flag rise while frozen
    p_no_flag_when_frozen_r10: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (sh_q.lock && !sh_q.flag) |=> !sh_q.flag);
    // R3: a copy leaves the flag set
    p_flag_on_copy_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
        copy_pulse && !sh_q.lock |=> sh_q.flag);
    // R4: a clear with no copy drops the flag
    p_flag_clear_r4: assert property (@(posedge bus_clk) disable iff (!rst_n)
        flag_clr && !copy_pulse |=> !sh_q.flag);
    // R7: a date read alone never freezes
    p_date_no_freeze_r7: assert property (@(posedge bus_clk) disable iff (!rst_n)
        rd_en && rd_sel == 2'd2 && !sh_q.lock |=> !sh_q.lock);
    // R8: bypass reads never freeze
    p_bypass_no_freeze_r8: assert property (@(posedge bus_clk) disable iff (!rst_n)
        rd_en && bypass && !sh_q.lock |=> !sh_q.lock);
endmodule

// File: tb/tb_cal_shadow_path.sv
module tb_cal_shadow_path;
    localparam int BUS_PERIOD = 10;
    localparam int RTC_PERIOD = 80;
    localparam int NVEC = 6;

    logic        rtc_clk = 0, bus_clk = 0, rst_n = 0;
    logic [15:0] live_ss = '0;
    logic [23:0] live_tm = '0, live_dt = '0;
    logic        bypass = 0, rd_en = 0, flag_clr = 0;
    logic [1:0]  rd_sel = 0;
    logic [23:0] rd_data;
    logic        sync_flag;
    int          n_chk = 0, n_fail = 0;

    always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
    always #(RTC_PERIOD/2) rtc_clk = ~rtc_clk;

    cal_shadow_path dut (
        .rtc_clk(rtc_clk), .bus_clk(bus_clk), .rst_n(rst_n),
        .live_subsec(live_ss), .live_time(live_tm), .live_date(live_dt),
        .bypass(bypass), .rd_en(rd_en), .rd_sel(rd_sel), .flag_clr(flag_clr),
        .rd_data(rd_data), .sync_flag(sync_flag)
    );

    // {subsec, time, date}
    localparam logic [63:0] VEC [NVEC] = '{
        {16'h0001, 24'h000001, 24'h000101},
        {16'hFFFF, 24'h235959, 24'h991231},
        {16'h8000, 24'h120000, 24'h250615},
        {16'h00FF, 24'hABCDEF, 24'h123456},
        {16'h5A5A, 24'hA5A5A5, 24'h5A5A5A},
        {16'h0000, 24'h000000, 24'h000000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_live(input logic [15:0] s, input logic [23:0] t, input logic [23:0] d);
        @(negedge rtc_clk);
        live_ss = s; live_tm = t; live_dt = d;
    endtask

    task automatic rd(input logic [1:0] s, output logic [23:0] v);
        @(negedge bus_clk);
        rd_en = 1; rd_sel = s;
        #1 v = rd_data;
        @(negedge bus_clk);
        rd_en = 0;
    endtask

    task automatic settle();
        repeat (6) @(posedge rtc_clk);
        @(negedge bus_clk);
    endtask

    task automatic clear_flag();
        @(negedge bus_clk); flag_clr = 1;
        @(negedge bus_clk); flag_clr = 0;
    endtask

    initial begin
        #(BUS_PERIOD * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [23:0] v;
        // R1: reset state
        live_ss = 16'h1234; live_tm = 24'h111111; live_dt = 24'h222222;
        repeat (3) @(negedge bus_clk);
        for (int s = 0; s < 3; s++) begin
            rd_sel = 2'(s); #1;
            check("R1 shadow zero", 32'(rd_data), 0);
        end
        check("R1 flag zero", 32'(sync_flag), 0);
        rst_n = 1;
        settle();
        check("R3 flag after copy", 32'(sync_flag), 1);

        // R2 / R9: table walk
        for (int i = 0; i < NVEC; i++) begin
            set_live(VEC[i][63:48], VEC[i][47:24], VEC[i][23:0]);
            settle();
            rd(2'd0, v); check("R2 R9 subsec", 32'(v), 32'(VEC[i][63:48]));
            rd(2'd1, v); check("R2 R9 time",   32'(v), 32'(VEC[i][47:24]));
            rd(2'd2, v); check("R2 R9 date",   32'(v), 32'(VEC[i][23:0]));
        end
        rd(2'd3, v); check("R9 sel 3 zero", 32'(v), 0);

        // R5 / R10 / R4 / R6: freeze and release
        set_live(16'h0A0A, 24'h0B0B0B, 24'h0C0C0C);
        settle();
        rd(2'd1, v); check("R5 time read", 32'(v), 32'h0B0B0B);
        clear_flag();
        #1 check("R4 flag cleared", 32'(sync_flag), 0);
        set_live(16'h1111, 24'h222222, 24'h333333);
        settle();
        check("R10 no flag while frozen", 32'(sync_flag), 0);
        rd(2'd0, v); check("R5 subsec frozen", 32'(v), 32'h0A0A);
        rd(2'd1, v); check("R5 time frozen", 32'(v), 32'h0B0B0B);
        rd(2'd2, v); check("R6 date frozen", 32'(v), 32'h0C0C0C);
        settle();
        check("R6 flag resumes", 32'(sync_flag), 1);
        rd(2'd1, v); check("R6 time resumes", 32'(v), 32'h222222);
        rd(2'd2, v); check("R6 date resumes", 32'(v), 32'h333333);

        // R7: date alone does not freeze
        rd(2'd2, v);
        set_live(16'h7777, 24'h777777, 24'h777777);
        settle();
        rd(2'd0, v); check("R7 no freeze from date", 32'(v), 32'h7777);
        rd(2'd2, v);

        // R8: bypass
        bypass = 1;
        set_live(16'hD00D, 24'hD0D0D0, 24'hDDDDDD);
        rd(2'd0, v); check("R8 bypass subsec", 32'(v), 32'hD00D);
        rd(2'd1, v); check("R8 bypass time", 32'(v), 32'hD0D0D0);
        rd(2'd2, v); check("R8 bypass date", 32'(v), 32'hDDDDDD);
        rd(2'd1, v);
        set_live(16'hEEEE, 24'hE0E0E0, 24'hEEEEEE);
        settle();
        bypass = 0;
        rd(2'd0, v); check("R8 bypass read no freeze", 32'(v), 32'hEEEE);
        rd(2'd2, v);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule